// File: doc/BRIEF.md
# Drain-Aware Reorder-Buffer Empty Notifier

This block sits in the commit stage of a multi-threaded out-of-order core. It tells the issue/execute stage when a thread's reorder buffer is empty in a way that stage can rely on. Occupancy reaching zero is not enough. The block reports "empty" only once no store is still waiting for writeback anywhere in the core. It also withholds the report in any cycle in which the thread itself retired a store, because the issue/execute stage has not yet seen that store.

Each thread has a pending-check flag. The flag is armed when a squash completes, or when an occupancy update finds the buffer empty. While the flag is armed, the block checks every cycle whether the drain conditions hold. On the first cycle they hold, it sends a single empty pulse and disarms. Squash completions and occupancy updates also forward the thread's current free-entry count, with a "used" marker. A strobe tells the receiver that the status bundle carries fresh content.

All outputs are registered, so a decision made from the inputs of cycle n is visible after the clock edge that ends cycle n. There is no data stream here: every pin is a level or a pulse, and there is no valid/ready handshake and no back-pressure. The receiver must accept the bundle in the cycle it appears.

Top module: `rob_empty_notify`

## Requirements
- R1: While rst_n is low, all outputs are zero and every thread's pending-check flag is clear.
- R2: In the first cycle after reset is released, used_rob_o and empty_rob_o are all ones, free_cnt_o carries every thread's input count, and wrote_o is 1. This start-up report happens once.
- R3: A squash_done_i or rob_update_i pulse for thread t arms t's pending-check flag if rob_empty_i[t] is 1 in that cycle. Once armed, the flag stays armed until a report is made, even if the buffer fills again in the meantime. Arming and reporting may happen in the same cycle.
- R4: empty_rob_o[t] goes high one cycle after a cycle in which all of these hold: t is armed (or is being armed), rob_empty_i[t]=1, stores_pending_i=0 and store_retired_i[t]=0.
- R5: A store retired by thread t (store_retired_i[t]=1) blocks t's report in that cycle only. If the other conditions hold in the next cycle, the report is made then.
- R6: Each arming produces at most one empty pulse. The report disarms the thread, and empty_rob_o[t] stays low in every cycle whose check fails.
- R7: squash_done_i[t] or rob_update_i[t] makes used_rob_o[t] high in the next cycle, together with t's count. These pulses alone never raise empty_rob_o[t] while the buffer is not empty.
- R8: wrote_o is high exactly when at least one bit of used_rob_o is high.
- R9: free_cnt_o for thread t (bits [t*CNT_W +: CNT_W]) takes the input count only in cycles where used_rob_o[t] rises for that send, and holds its value otherwise.
- R10: Threads are independent. Stimulus on one thread never changes another thread's outputs, apart from the shared stores_pending_i input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rob_empty_i | input | NUM_THR | Per-thread buffer occupancy is zero |
| stores_pending_i | input | 1 | Some store anywhere still awaits writeback |
| store_retired_i | input | NUM_THR | Thread retired a store this cycle |
| squash_done_i | input | NUM_THR | Thread finished squashing this cycle |
| rob_update_i | input | NUM_THR | Thread's occupancy changed this cycle |
| free_cnt_i | input | NUM_THR*CNT_W | Per-thread free-entry counts, thread t at [t*CNT_W +: CNT_W] |
| used_rob_o | output | NUM_THR | Bundle for thread t carries a fresh count |
| empty_rob_o | output | NUM_THR | Drained-empty pulse per thread |
| free_cnt_o | output | NUM_THR*CNT_W | Last forwarded free-entry counts |
| wrote_o | output | 1 | Bundle carries new content this cycle |

## Verification
The bench first arms a thread with nothing in the way, which shows that arming and reporting can happen in the same cycle. It then holds the global store-pending flag for several cycles, which shows that the armed state survives the wait. A store retirement on the same cycle as arming shows the report moving exactly one cycle later. A squash with a non-empty buffer, followed by the buffer emptying with no event, shows that emptiness alone never causes a report. Mixed multi-thread cycles and a long random run separate a correct per-thread slice from one that leaks state between threads or emits repeated pulses.

// File: rtl/rob_empty_pkg.sv
package rob_empty_pkg;
  function automatic int cnt_bits(input int depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/rob_empty_init.sv
module rob_empty_init (
  input  logic clk,
  input  logic rst_n,
  output logic init_o
);
  logic first_q;

  always_ff @(posedge clk) begin
    if (!rst_n) first_q <= 1'b1;
    else        first_q <= 1'b0;
  end

  assign init_o = first_q;

  // R2
  init_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_o |=> !init_o);
endmodule

// File: rtl/rob_empty_thread.sv
module rob_empty_thread #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic             rob_empty_i,
  input  logic             stores_pending_i,
  input  logic             store_retired_i,
  input  logic             squash_done_i,
  input  logic             rob_update_i,
  input  logic [CNT_W-1:0] free_cnt_i,
  output logic             send_o,
  output logic             used_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] free_cnt_o
);
  logic pend_q;
  logic store_now;
  logic event_now;
  logic armed;
  logic report;

  // per-cycle store flag: cleared every cycle, set by a retiring store
  assign store_now = store_retired_i;
  assign event_now = squash_done_i | rob_update_i;
  assign armed     = pend_q | (event_now & rob_empty_i);
  assign report    = armed & rob_empty_i & ~stores_pending_i & ~store_now;
  assign send_o    = event_now | report | init_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      used_o     <= 1'b0;
      empty_o    <= 1'b0;
      free_cnt_o <= '0;
    end else begin
      pend_q  <= armed & ~report;
      used_o  <= send_o;
      empty_o <= report | init_i;
      if (send_o) free_cnt_o <= free_cnt_i;
    end
  end

  // R4
  empty_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> $past(init_i || (rob_empty_i && !stores_pending_i && !store_retired_i)));

  // R5
  store_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (store_retired_i && !init_i) |=> !empty_o);

  // R6
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && !$past(init_i)) |-> !pend_q);

  // R7
  empty_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> used_o);

  // R9
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !used_o |-> $stable(free_cnt_o));
endmodule

// File: rtl/rob_empty_notify.sv
module rob_empty_notify #(
  parameter int NUM_THR   = 4,
  parameter int ROB_DEPTH = 32,
  parameter int CNT_W     = rob_empty_pkg::cnt_bits(ROB_DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_THR-1:0]       rob_empty_i,
  input  logic                     stores_pending_i,
  input  logic [NUM_THR-1:0]       store_retired_i,
  input  logic [NUM_THR-1:0]       squash_done_i,
  input  logic [NUM_THR-1:0]       rob_update_i,
  input  logic [NUM_THR*CNT_W-1:0] free_cnt_i,
  output logic [NUM_THR-1:0]       used_rob_o,
  output logic [NUM_THR-1:0]       empty_rob_o,
  output logic [NUM_THR*CNT_W-1:0] free_cnt_o,
  output logic                     wrote_o
);
  logic               init;
  logic [NUM_THR-1:0] send;
  logic               wrote_q;

  rob_empty_init u_init (
    .clk    (clk),
    .rst_n  (rst_n),
    .init_o (init)
  );

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    rob_empty_thread #(.CNT_W(CNT_W)) u_thr (
      .clk              (clk),
      .rst_n            (rst_n),
      .init_i           (init),
      .rob_empty_i      (rob_empty_i[t]),
      .stores_pending_i (stores_pending_i),
      .store_retired_i  (store_retired_i[t]),
      .squash_done_i    (squash_done_i[t]),
      .rob_update_i     (rob_update_i[t]),
      .free_cnt_i       (free_cnt_i[t*CNT_W +: CNT_W]),
      .send_o           (send[t]),
      .used_o           (used_rob_o[t]),
      .empty_o          (empty_rob_o[t]),
      .free_cnt_o       (free_cnt_o[t*CNT_W +: CNT_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wrote_q <= 1'b0;
    else        wrote_q <= |send;
  end

  assign wrote_o = wrote_q;

  // R8
  wrote_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrote_o == (|used_rob_o));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (used_rob_o == '0 && empty_rob_o == '0 && !wrote_o));
endmodule

// File: tb/rob_empty_notify_tb.sv
module rob_empty_notify_tb;
  localparam int NT = 4;
  localparam int FW = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NT-1:0]    rob_empty_i = '0;
  logic             stores_pending_i = 1'b0;
  logic [NT-1:0]    store_retired_i = '0;
  logic [NT-1:0]    squash_done_i = '0;
  logic [NT-1:0]    rob_update_i = '0;
  logic [NT*FW-1:0] free_cnt_i = '0;
  logic [NT-1:0]    used_rob_o;
  logic [NT-1:0]    empty_rob_o;
  logic [NT*FW-1:0] free_cnt_o;
  logic             wrote_o;

  always #4 clk = ~clk;

  rob_empty_notify #(.NUM_THR(NT), .ROB_DEPTH(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .rob_empty_i(rob_empty_i),
    .stores_pending_i(stores_pending_i), .store_retired_i(store_retired_i),
    .squash_done_i(squash_done_i), .rob_update_i(rob_update_i),
    .free_cnt_i(free_cnt_i), .used_rob_o(used_rob_o),
    .empty_rob_o(empty_rob_o), .free_cnt_o(free_cnt_o), .wrote_o(wrote_o)
  );

  typedef struct {
    logic [NT-1:0]    used;
    logic [NT-1:0]    empty;
    logic [NT*FW-1:0] free;
    logic             wrote;
    string            tag;
  } exp_t;

  exp_t          sb[$];
  int            checks = 0;
  int            fails = 0;
  bit            done = 0;
  logic [NT-1:0] m_pend = '0;
  logic          m_init = 1'b1;
  logic [NT*FW-1:0] m_free = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [NT-1:0] emp, input logic sp,
                       input logic [NT-1:0] sr, input logic [NT-1:0] sq,
                       input logic [NT-1:0] up, input string tag);
    exp_t e;
    logic [NT*FW-1:0] fr;
    fr = {$urandom, $urandom};
    rob_empty_i = emp; stores_pending_i = sp; store_retired_i = sr;
    squash_done_i = sq; rob_update_i = up; free_cnt_i = fr;
    e.tag = tag;
    for (int t = 0; t < NT; t++) begin
      logic ev, arm, rep, snd;
      ev  = sq[t] | up[t];
      arm = m_pend[t] | (ev & emp[t]);
      rep = arm & emp[t] & ~sp & ~sr[t];
      m_pend[t] = arm & ~rep;
      snd = ev | rep | m_init;
      e.used[t]  = snd;
      e.empty[t] = rep | m_init;
      if (snd) m_free[t*FW +: FW] = fr[t*FW +: FW];
    end
    m_init = 1'b0;
    e.free  = m_free;
    e.wrote = |e.used;
    sb.push_back(e);
  endtask

  task automatic step(input logic [NT-1:0] emp, input logic sp,
                      input logic [NT-1:0] sr, input logic [NT-1:0] sq,
                      input logic [NT-1:0] up, input string tag);
    @(negedge clk);
    drive(emp, sp, sr, sq, up, tag);
  endtask

  // monitor: pops the expectation for the edge just passed
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " empty"}, 64'(empty_rob_o), 64'(e.empty));
        chk("R7 used", 64'(used_rob_o), 64'(e.used));
        chk("R9 free", 64'(free_cnt_o), 64'(e.free));
        chk("R8 wrote", 64'(wrote_o), 64'(e.wrote));
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 used", 64'(used_rob_o), 64'd0);
    chk("R1 empty", 64'(empty_rob_o), 64'd0);
    chk("R1 wrote", 64'(wrote_o), 64'd0);
    rst_n = 1'b1;
    drive('0, 1'b0, '0, '0, '0, "R2");            // start-up report
    step('1, 1'b0, '0, '0, '0, "R2");             // no repeat
    step('1, 1'b0, '0, '0, '0, "R6");
    // R3: squash while empty, report same cycle as arming
    step(4'b0001, 1'b0, '0, 4'b0001, '0, "R3");
    step(4'b0001, 1'b0, '0, '0, '0, "R6");        // no second pulse
    // R4: stores pending delays report; armed state survives
    step(4'b0010, 1'b1, '0, 4'b0010, '0, "R4");
    step(4'b0000, 1'b1, '0, '0, '0, "R4");
    step(4'b0010, 1'b1, '0, '0, '0, "R4");
    step(4'b0010, 1'b0, '0, '0, '0, "R4");
    step(4'b0010, 1'b0, '0, '0, '0, "R6");
    // R5: store retired blocks only that cycle
    step(4'b0100, 1'b0, 4'b0100, '0, 4'b0100, "R5");
    step(4'b0100, 1'b0, '0, '0, '0, "R5");
    // R7: squash with non-empty buffer never reports
    step(4'b0000, 1'b0, '0, 4'b1000, '0, "R7");
    step(4'b1000, 1'b0, '0, '0, '0, "R7");
    step(4'b1000, 1'b0, '0, '0, '0, "R9");
    // R10: mixed threads, store on one does not block another
    step(4'b1111, 1'b0, 4'b0101, 4'b1111, '0, "R10");
    step(4'b1111, 1'b0, 4'b0001, '0, '0, "R10");
    step(4'b1111, 1'b0, '0, '0, '0, "R10");
    for (int i = 0; i < 400; i++) begin
      step(NT'($urandom | $urandom), ($urandom % 3) == 0, NT'($urandom & $urandom),
           NT'($urandom & $urandom), NT'($urandom & $urandom & $urandom), "R4");
    end
    step('0, 1'b0, '0, '0, '0, "R6");
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule